// File: doc/BRIEF.md
# PWM Time-Base Counter with Two-Stage Prescaler

This block is the timing core shared by the channels of a two-channel pulse-width modulator. It divides the functional clock with a two-stage prescaler and steps a 16-bit counter against an active period value. From the count it produces a zero-match strobe and a period-match strobe, and it exposes the live count to the compare stages that follow.

Software sets it up through a narrow register write port. Address 0 holds a 16-bit control word that chooses the counting direction, the run or stop behaviour, how a new period is loaded and the two divider fields. Address 1 holds the period. A period can go into a shadow register and be applied at the next zero of the count, so a waveform is never cut off mid-cycle. It can also be applied at once. A stop request can halt the counter at once, or let it finish the current cycle and park at zero.

Top module: `tbase_top`

## Requirements
- R1: A synchronous active-high reset clears the count and the active and shadow periods to 0. It loads a control word of 0x0003, which means freeze and halt, with both dividers at 1. The strobes stay low while the block is frozen.
- R2: With the mode field (control bits 1:0) at 00, each prescaled tick raises the count by 1. After the count reaches the active period, the next tick returns it to 0.
- R3: With the mode field at 01, each tick lowers the count by 1. A tick at count 0 reloads the active period.
- R4: With the mode field at 10, the count rises to the active period and then falls back to 0. The direction changes on the tick taken at either end, so no end value is repeated.
- R5: With the mode field at 11, the count holds its value and both strobes stay low.
- R6: With the run field (control bits 15:14) at 00, the count takes at most one more step, the one on the edge that writes the control word. After that it holds, with both strobes low.
- R7: With the run field at 01, counting continues until the count arrives at 0, then holds at 0 with both strobes low. Run values 10 and 11 count without limit.
- R8: The count advances once every D clocks, where D = 2^C * H. C is control bits 12:10. H is 1 when control bits 9:7 are 0, and twice that field value otherwise.
- R9: With control bit 3 at 1, a period write replaces the active period on the write edge.
- R10: With control bit 3 at 0, a period write goes only to the shadow register. The active period takes the shadow value on the tick at which the count leaves 0.
- R11: zero_stb is high exactly while the counter is counting and the count is 0. prd_stb is high exactly while the counter is counting and the count equals the active period.
- R12: A write with wr_en high stores wr_data as the control word when wr_addr is 0, and as the period when wr_addr is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects control, 1 selects period |
| wr_data | input | 16 | Write data |
| count | output | 16 | Live counter value |
| zero_stb | output | 1 | Count-at-zero event |
| prd_stb | output | 1 | Count-at-period event |

## Verification
The bound checker watches on every cycle that a frozen or halted counter does not move. It also watches that up mode only steps by one, wraps to zero or holds, that each strobe agrees with the count and the active period, and that the count leaves reset at zero. Only the bench scenarios can show the things that depend on a whole sequence of writes. These are the exact divide ratio of each prescaler setting, the reversal points of up-down mode, and a finishing stop that parks at zero after a wrap. They also include whether a shadowed period is held back until the zero tick while an immediate one takes effect on the write edge.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

    localparam int SEL_W  = 3;
    localparam int DATA_W = 16;
    localparam int DIV_W  = ((1 << SEL_W) - 1) + $clog2(2 * ((1 << SEL_W) - 1) + 1);

    typedef enum logic [1:0] {
        CM_UP   = 2'b00,
        CM_DOWN = 2'b01,
        CM_UPDN = 2'b10,
        CM_HOLD = 2'b11
    } cnt_mode_e;

    typedef enum logic [1:0] {
        RUN_HALT   = 2'b00,
        RUN_FINISH = 2'b01,
        RUN_FREE_A = 2'b10,
        RUN_FREE   = 2'b11
    } run_mode_e;

    typedef struct packed {
        run_mode_e        run;
        logic             spare13;
        logic [SEL_W-1:0] coarse;
        logic [SEL_W-1:0] fine;
        logic [2:0]       spare6;
        logic             imm_load;
        logic             spare2;
        cnt_mode_e        mode;
    } ctl_t;

    localparam logic [DATA_W-1:0] CTL_RESET = 16'h0003;

    function automatic logic [DIV_W-1:0] tick_divisor(
        input logic [SEL_W-1:0] coarse,
        input logic [SEL_W-1:0] fine
    );
        logic [DIV_W-1:0] pow2;
        logic [DIV_W-1:0] mult;
        pow2 = DIV_W'(1) << coarse;
        mult = (fine == '0) ? DIV_W'(1) : (DIV_W'(fine) << 1);
        return DIV_W'(pow2 * mult);
    endfunction

endpackage

// File: rtl/tbase_regs.sv
module tbase_regs
    import tbase_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load_shadow,
    output ctl_t              ctl_q,
    output logic [CNT_W-1:0]  prd_act
);
    logic [CNT_W-1:0] prd_shadow;
    logic             wr_ctl;
    logic             wr_prd;

    assign wr_ctl = wr_en && (wr_addr == 1'b0);
    assign wr_prd = wr_en && (wr_addr == 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= ctl_t'(CTL_RESET);
        end else if (wr_ctl) begin
            ctl_q <= ctl_t'(wr_data);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prd_shadow <= '0;
            prd_act    <= '0;
        end else begin
            if (wr_prd) begin
                prd_shadow <= wr_data[CNT_W-1:0];
            end
            if (wr_prd && ctl_q.imm_load) begin
                prd_act <= wr_data[CNT_W-1:0];
            end else if (load_shadow && !ctl_q.imm_load) begin
                prd_act <= prd_shadow;
            end
        end
    end
endmodule

// File: rtl/tbase_prescale.sv
module tbase_prescale
    import tbase_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             counting,
    input  logic [SEL_W-1:0] coarse,
    input  logic [SEL_W-1:0] fine,
    output logic             tick
);
    logic [DIV_W-1:0] pre_cnt;
    logic [DIV_W-1:0] div_last;

    assign div_last = tick_divisor(coarse, fine) - DIV_W'(1);
    assign tick     = counting && (pre_cnt >= div_last);

    always_ff @(posedge clk) begin
        if (rst || !counting || tick) begin
            pre_cnt <= '0;
        end else begin
            pre_cnt <= pre_cnt + DIV_W'(1);
        end
    end
endmodule

// File: rtl/tbase_counter.sv
module tbase_counter
    import tbase_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  cnt_mode_e        mode,
    input  run_mode_e        run,
    input  logic [CNT_W-1:0] prd_act,
    output logic [CNT_W-1:0] cnt,
    output logic             counting
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic going_down;

    assign counting = (mode != CM_HOLD) && (run != RUN_HALT) &&
                      !((run == RUN_FINISH) && (cnt == '0));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt        <= '0;
            going_down <= 1'b0;
        end else begin
            if (mode != CM_UPDN) begin
                going_down <= 1'b0;
            end
            if (tick) begin
                unique case (mode)
                    CM_UP: begin
                        cnt <= (cnt >= prd_act) ? '0 : cnt + ONE;
                    end
                    CM_DOWN: begin
                        cnt <= (cnt == '0) ? prd_act : cnt - ONE;
                    end
                    CM_UPDN: begin
                        if (!going_down) begin
                            if (cnt >= prd_act) begin
                                going_down <= 1'b1;
                                cnt        <= (cnt == '0) ? '0 : cnt - ONE;
                            end else begin
                                cnt <= cnt + ONE;
                            end
                        end else begin
                            if (cnt == '0) begin
                                going_down <= 1'b0;
                                cnt        <= (prd_act == '0) ? '0 : ONE;
                            end else begin
                                cnt <= cnt - ONE;
                            end
                        end
                    end
                    default: begin
                        cnt <= cnt;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/tbase_top.sv
module tbase_top
    import tbase_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  count,
    output logic              zero_stb,
    output logic              prd_stb
);
    ctl_t             ctl_q;
    logic [CNT_W-1:0] prd_act;
    logic             tick;
    logic             counting;
    logic             load_shadow;

    assign zero_stb    = counting && (count == '0);
    assign prd_stb     = counting && (count == prd_act);
    assign load_shadow = tick && zero_stb;

    tbase_regs #(.CNT_W(CNT_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .load_shadow (load_shadow),
        .ctl_q       (ctl_q),
        .prd_act     (prd_act)
    );

    tbase_prescale u_pre (
        .clk      (clk),
        .rst      (rst),
        .counting (counting),
        .coarse   (ctl_q.coarse),
        .fine     (ctl_q.fine),
        .tick     (tick)
    );

    tbase_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .mode     (ctl_q.mode),
        .run      (ctl_q.run),
        .prd_act  (prd_act),
        .cnt      (count),
        .counting (counting)
    );
endmodule

// File: rtl/tbase_chk.sv
module tbase_chk
    import tbase_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input ctl_t             ctl_q,
    input logic [CNT_W-1:0] prd_act,
    input logic [CNT_W-1:0] count,
    input logic             zero_stb,
    input logic             prd_stb
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (count == '0 && !zero_stb && !prd_stb));

    // R5
    freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.mode == CM_HOLD) |=> $stable(count));

    // R6
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.run == RUN_HALT) |=> $stable(count));

    // R2
    up_step_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.mode == CM_UP) |=>
            (count == $past(count) + CNT_W'(1) || count == '0 || $stable(count)));

    // R11
    zero_stb_chk: assert property (@(posedge clk) disable iff (rst)
        zero_stb |-> (count == '0));

    // R11
    prd_stb_chk: assert property (@(posedge clk) disable iff (rst)
        prd_stb |-> (count == prd_act));

    // R11
    both_stb_chk: assert property (@(posedge clk) disable iff (rst)
        (zero_stb && prd_stb) |-> (prd_act == '0));
endmodule

bind tbase_top tbase_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ctl_q    (ctl_q),
    .prd_act  (prd_act),
    .count    (count),
    .zero_stb (zero_stb),
    .prd_stb  (prd_stb)
);

// File: tb/tbase_top_tb.sv
module tbase_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 11;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] count;
    logic        zero_stb;
    logic        prd_stb;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    // columns: control word, period, clocks to wait, expected count
    localparam logic [15:0] VEC [0:NVEC-1][0:3] = '{
        '{16'hC008, 16'd5,  16'd3,  16'd3},  // R2 up
        '{16'hC008, 16'd5,  16'd6,  16'd0},  // R2 wrap
        '{16'hC008, 16'd5,  16'd8,  16'd2},  // R2 after wrap
        '{16'hC009, 16'd5,  16'd3,  16'd3},  // R3 down reload
        '{16'hC00A, 16'd3,  16'd5,  16'd1},  // R4 falling
        '{16'hC00A, 16'd3,  16'd6,  16'd0},  // R4 back at zero
        '{16'hC408, 16'd10, 16'd8,  16'd4},  // R8 coarse=1 div 2
        '{16'hC188, 16'd10, 16'd12, 16'd2},  // R8 fine=3 div 6
        '{16'hC488, 16'd10, 16'd20, 16'd5},  // R8 both div 4
        '{16'hC00B, 16'd5,  16'd10, 16'd0},  // R5 freeze
        '{16'h4008, 16'd5,  16'd10, 16'd0}   // R7 finish at zero
    };

    tbase_top u_dut (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .count    (count),
        .zero_stb (zero_stb),
        .prd_stb  (prd_stb)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic reg_write(input logic addr, input logic [15:0] data);
        wr_en   = 1'b1;
        wr_addr = addr;
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic start(input logic [15:0] ctl, input logic [15:0] prd);
        do_reset();
        reg_write(1'b0, 16'h000B);
        reg_write(1'b1, prd);
        reg_write(1'b0, ctl);
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset();
        check("R1 count", count, 16'd0);
        check("R1 zero_stb", {15'd0, zero_stb}, 16'd0);
        check("R1 prd_stb", {15'd0, prd_stb}, 16'd0);
        repeat (4) @(negedge clk);
        check("R1 frozen", count, 16'd0);

        for (int i = 0; i < NVEC; i++) begin
            start(VEC[i][0], VEC[i][1]);
            repeat (int'(VEC[i][2])) @(negedge clk);
            check($sformatf("R12 vector %0d", i), count, VEC[i][3]);
        end

        // R11 strobes
        start(16'hC008, 16'd3);
        check("R11 zero_stb at 0", {15'd0, zero_stb}, 16'd1);
        check("R11 prd_stb at 0", {15'd0, prd_stb}, 16'd0);
        repeat (3) @(negedge clk);
        check("R11 count", count, 16'd3);
        check("R11 prd_stb at prd", {15'd0, prd_stb}, 16'd1);
        check("R11 zero_stb at prd", {15'd0, zero_stb}, 16'd0);

        // R7 finishing stop
        start(16'hC008, 16'd4);
        repeat (2) @(negedge clk);
        reg_write(1'b0, 16'h4008);
        check("R7 step on write", count, 16'd3);
        repeat (5) @(negedge clk);
        check("R7 parked", count, 16'd0);
        check("R7 no zero_stb", {15'd0, zero_stb}, 16'd0);

        // R6 immediate stop
        start(16'hC008, 16'd9);
        repeat (4) @(negedge clk);
        reg_write(1'b0, 16'h0008);
        check("R6 last step", count, 16'd5);
        repeat (5) @(negedge clk);
        check("R6 held", count, 16'd5);
        check("R6 no prd_stb", {15'd0, prd_stb}, 16'd0);

        // R5 freeze mid-run
        start(16'hC008, 16'd9);
        repeat (3) @(negedge clk);
        reg_write(1'b0, 16'hC00B);
        repeat (4) @(negedge clk);
        check("R5 held", count, 16'd4);
        check("R5 no zero_stb", {15'd0, zero_stb}, 16'd0);

        // R9 immediate period load
        start(16'hC008, 16'd5);
        repeat (2) @(negedge clk);
        reg_write(1'b1, 16'd8);
        repeat (5) @(negedge clk);
        check("R9 beyond old period", count, 16'd8);
        check("R9 prd_stb", {15'd0, prd_stb}, 16'd1);
        @(negedge clk);
        check("R9 wrap", count, 16'd0);

        // R10 shadow period load
        start(16'hC000, 16'd5);
        repeat (2) @(negedge clk);
        reg_write(1'b1, 16'd2);
        repeat (2) @(negedge clk);
        check("R10 old period kept", count, 16'd5);
        check("R10 prd_stb old", {15'd0, prd_stb}, 16'd1);
        repeat (3) @(negedge clk);
        check("R10 new count", count, 16'd2);
        check("R10 prd_stb new", {15'd0, prd_stb}, 16'd1);
        @(negedge clk);
        check("R10 wrap at new", count, 16'd0);

        // R1 reset mid-run
        start(16'hC008, 16'd9);
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid-run reset", count, 16'd0);
        rst = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule